// File: doc/BRIEF.md
# Write Status Polling Responder

This block stands in for a flash array while an internal program or erase runs. A command decoder hands it one start pulse per operation, carrying an operation kind, a word address and a data word. The block then holds a busy flag for a parameterised number of clock cycles chosen by the kind. For that whole time, reads return a status word instead of array contents. When the timer expires, the block commits the operation to a small behavioural word array. Every read after that returns true data.

The status word gives software two ways to find the end of a write. Bit 7 carries a polarity hint. For a program it is the complement of bit 7 of the word being written; for any erase it reads 0. Bit 6 inverts on every read made while the operation runs. The decoder watches the busy flag so that it can drop commands that arrive while an operation is in flight. Durations are given in clock cycles, and their default ratios follow typical program, sector/block erase and chip erase times.

Top module: `wsp_responder`

## Requirements
- R1: While reset is held, `busy` is 0 and `rd_data` is 0.
- R2: An `op_start` sampled while `busy` is 0 raises `busy` on the next cycle. `busy` then stays high for exactly the cycle count of the kind: `op_kind` 0 is a word program (`PROG_CYC`), 1 a sector erase (`SECT_CYC`), 2 a block erase (`BLK_CYC`), 3 a chip erase (`CHIP_CYC`).
- R3: An `op_start` sampled while `busy` is 1 has no effect. It does not change the busy length, the status word or any array word.
- R4: A read sampled with `rd_en` appears on `rd_data` one cycle later and is then held until the next read. While `busy` is 0 it returns the array word at `rd_addr`.
- R5: While `busy` is 1, bit 7 of a read result is the complement of bit 7 of the programmed word for a program, and 0 for any erase.
- R6: While `busy` is 1, bit 6 of the first read after a start is 0. Each later read in the same operation returns the inverse of the previous one. Cycles without `rd_en` do not advance it.
- R7: While `busy` is 1, bits 15..8 and 5..0 of every read result are 0.
- R8: A program stores `op_wdata` at `op_addr`. The first read sampled after `busy` falls returns the new word.
- R9: A sector erase sets to FFFFh every word whose address equals `op_addr` above its lowest `SECT_W` bits, and leaves the others unchanged.
- R10: A block erase does the same for the words that share `op_addr` above its lowest `BLK_W` bits.
- R11: A chip erase sets every word of the array to FFFFh.
- R12: A read sampled in the same cycle as an accepted `op_start` returns the array contents from before that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_start | input | 1 | One-cycle start pulse from the command decoder |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 block erase, 3 chip erase |
| op_addr | input | ADDR_W | Target word address (selects the sector or block for erases) |
| op_wdata | input | 16 | Word to program |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | 16 | Read result, one cycle after the request |
| busy | output | 1 | High while an internal operation runs |

## Verification
`busy` is due on the cycle after the accepting edge and falls exactly the kind's cycle count later. Every read result is due one edge after `rd_en` is sampled. The reference model in the bench advances once per rising edge using the inputs that were stable at that edge. The bench compares `busy` and `rd_data` with the model at every falling edge, so each value is checked half a cycle after the edge that produced it. Reads placed on the last busy cycle, on the first idle cycle and on the start cycle itself pin down where status ends and true data begins.

// File: rtl/wsp_pkg.sv
package wsp_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    OP_PROG = 2'd0,
    OP_SECT = 2'd1,
    OP_BLK  = 2'd2,
    OP_CHIP = 2'd3
  } op_kind_e;

endpackage

// File: rtl/wsp_timer.sv
module wsp_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done   = busy_q && (cnt_q == CNT_W'(1));
    if (load) begin
      cnt_d  = load_val;
      busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/wsp_toggle_status.sv
module wsp_toggle_status
  import wsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              rd_hit,
  input  logic              is_prog,
  input  logic              prog_bit7,
  output logic [WORD_W-1:0] status
);

  logic tog_q, tog_d;

  always_comb begin
    tog_d = tog_q;
    if (clear)       tog_d = 1'b0;
    else if (rd_hit) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end

  always_comb begin
    status    = '0;
    status[7] = is_prog ? ~prog_bit7 : 1'b0;
    status[6] = tog_q;
  end

endmodule

// File: rtl/wsp_array.sv
module wsp_array
  import wsp_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SECT_W = 4,
  parameter int BLK_W  = 7
) (
  input  logic              clk,
  input  logic              commit,
  input  op_kind_e          kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  int                erase_sh;

  always_comb begin
    case (kind)
      OP_SECT: erase_sh = SECT_W;
      OP_BLK:  erase_sh = BLK_W;
      default: erase_sh = ADDR_W;
    endcase
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      if (kind == OP_PROG) begin
        mem_q[addr] <= wdata;
      end else begin
        for (int i = 0; i < DEPTH; i++) begin
          if ((ADDR_W'(i) >> erase_sh) == (addr >> erase_sh)) mem_q[i] <= '1;
        end
      end
    end
  end

  assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/wsp_responder.sv
module wsp_responder
  import wsp_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SECT_W   = 4,
  parameter int BLK_W    = 7,
  parameter int PROG_CYC = 2800,
  parameter int SECT_CYC = 3600000,
  parameter int BLK_CYC  = 3600000,
  parameter int CHIP_CYC = 14000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [15:0]       op_wdata,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic              busy
);

  localparam int MAX_A   = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_B   = (BLK_CYC > CHIP_CYC) ? BLK_CYC : CHIP_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  // reset: asserted at once, released through two flops
  logic rst_s1, rst_s2, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign rst_ni = rst_s2;

  logic              busy_w, done_w, accept;
  logic [CNT_W-1:0]  dur;
  op_kind_e          kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] status_w, arr_word;
  logic [WORD_W-1:0] rd_q, rd_d;

  assign accept = op_start && !busy_w;

  always_comb begin
    case (op_kind_e'(op_kind))
      OP_PROG: dur = CNT_W'(PROG_CYC);
      OP_SECT: dur = CNT_W'(SECT_CYC);
      OP_BLK:  dur = CNT_W'(BLK_CYC);
      default: dur = CNT_W'(CHIP_CYC);
    endcase
  end

  always_comb begin
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    if (accept) begin
      kind_d = op_kind_e'(op_kind);
      addr_d = op_addr;
      data_d = op_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  wsp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (accept),
    .load_val (dur),
    .busy     (busy_w),
    .done     (done_w)
  );

  wsp_toggle_status u_status (
    .clk       (clk),
    .rst_n     (rst_ni),
    .clear     (accept),
    .rd_hit    (rd_en && busy_w),
    .is_prog   (kind_q == OP_PROG),
    .prog_bit7 (data_q[7]),
    .status    (status_w)
  );

  wsp_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_array (
    .clk     (clk),
    .commit  (done_w),
    .kind    (kind_q),
    .addr    (addr_q),
    .wdata   (data_q),
    .rd_addr (rd_addr),
    .rd_word (arr_word)
  );

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = busy_w ? status_w : arr_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign busy    = busy_w;

endmodule

// File: rtl/wsp_responder_chk.sv
module wsp_responder_chk #(
  parameter int ADDR_W   = 10,
  parameter int PROG_CYC = 2800,
  parameter int SECT_CYC = 3600000,
  parameter int BLK_CYC  = 3600000,
  parameter int CHIP_CYC = 14000000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_start,
  input logic [1:0]  op_kind,
  input logic [15:0] op_wdata,
  input logic        rd_en,
  input logic [15:0] rd_data,
  input logic        busy
);

  int   run_cnt, exp_len;
  logic k_prog, d7, rd_st_q, had_rd, last6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= 0;
      exp_len <= 0;
      k_prog  <= 1'b0;
      d7      <= 1'b0;
      rd_st_q <= 1'b0;
      had_rd  <= 1'b0;
      last6   <= 1'b0;
    end else begin
      rd_st_q <= rd_en && busy;
      if (op_start && !busy) begin
        run_cnt <= 0;
        k_prog  <= (op_kind == 2'd0);
        d7      <= op_wdata[7];
        had_rd  <= 1'b0;
        case (op_kind)
          2'd0:    exp_len <= PROG_CYC;
          2'd1:    exp_len <= SECT_CYC;
          2'd2:    exp_len <= BLK_CYC;
          default: exp_len <= CHIP_CYC;
        endcase
      end else begin
        if (busy) run_cnt <= run_cnt + 1;
        if (rd_st_q) begin
          had_rd <= 1'b1;
          last6  <= rd_data[6];
        end
      end
    end
  end

  AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !busy) |=> busy); // R2

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == exp_len)); // R2

  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(op_start)); // R3

  AST_DQ7_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[7] == (k_prog ? ~d7 : 1'b0))); // R5

  AST_DQ6_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st_q && !had_rd) |-> (rd_data[6] == 1'b0)); // R6

  AST_DQ6_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st_q && had_rd) |-> (rd_data[6] != last6)); // R6

  AST_STATUS_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> ((rd_data[15:8] == 8'h00) && (rd_data[5:0] == 6'h00))); // R7

endmodule

bind wsp_responder wsp_responder_chk #(
  .ADDR_W   (ADDR_W),
  .PROG_CYC (PROG_CYC),
  .SECT_CYC (SECT_CYC),
  .BLK_CYC  (BLK_CYC),
  .CHIP_CYC (CHIP_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_start (op_start),
  .op_kind  (op_kind),
  .op_wdata (op_wdata),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .busy     (busy)
);

// File: tb/wsp_responder_tb_top.sv
`timescale 1ns/1ps
module wsp_responder_tb_top;

  localparam int AW    = 8;
  localparam int SW    = 3;
  localparam int BW    = 5;
  localparam int TP    = 6;
  localparam int TS    = 12;
  localparam int TB    = 16;
  localparam int TC    = 20;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_start = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [15:0]   op_wdata = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic          busy;

  always #2.5 clk = ~clk;

  wsp_responder #(
    .ADDR_W(AW), .SECT_W(SW), .BLK_W(BW),
    .PROG_CYC(TP), .SECT_CYC(TS), .BLK_CYC(TB), .CHIP_CYC(TC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_kind(op_kind),
    .op_addr(op_addr), .op_wdata(op_wdata), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  logic [15:0] mem [DEPTH];
  string       wtag [DEPTH];
  bit          m_en = 1'b0;
  bit          m_busy = 1'b0, m_ign = 1'b0, m_tog = 1'b0, m_prog = 1'b0, m_d7 = 1'b0;
  bit          m_stat = 1'b0, was_busy;
  int          m_rem = 0, m_kind = 0;
  logic [AW-1:0] m_addr = '0;
  logic [15:0] m_data = '0;
  logic [15:0] e_rd = '0;
  string       e_tag = "R4";

  function automatic int dur_of(input int k);
    case (k)
      0: return TP;
      1: return TS;
      2: return TB;
      default: return TC;
    endcase
  endfunction

  always @(posedge clk) begin
    if (m_en) begin
      was_busy = m_busy;
      if (rd_en) begin
        if (was_busy) begin
          m_stat = 1'b1;
          e_rd = 16'h0000;
          e_rd[7] = m_prog ? ~m_d7 : 1'b0;
          e_rd[6] = m_tog;
          m_tog = ~m_tog;
        end else begin
          m_stat = 1'b0;
          e_rd = mem[rd_addr];
          e_tag = op_start ? "R12" : wtag[rd_addr];
        end
      end
      if (op_start && !was_busy) begin
        m_busy = 1'b1;
        m_kind = int'(op_kind);
        m_rem  = dur_of(m_kind);
        m_addr = op_addr;
        m_data = op_wdata;
        m_prog = (op_kind == 2'd0);
        m_d7   = op_wdata[7];
        m_tog  = 1'b0;
        m_ign  = 1'b0;
      end else if (was_busy) begin
        if (op_start) m_ign = 1'b1;
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 1'b0;
          if (m_kind == 0) begin
            mem[m_addr]  = m_data;
            wtag[m_addr] = "R8";
          end else begin
            for (int i = 0; i < DEPTH; i++) begin
              int sh;
              sh = (m_kind == 1) ? SW : (m_kind == 2) ? BW : AW;
              if ((i >> sh) == (int'(m_addr) >> sh)) begin
                mem[i]  = 16'hFFFF;
                wtag[i] = (m_kind == 1) ? "R9" : (m_kind == 2) ? "R10" : "R11";
              end
            end
          end
        end
      end
    end
  end

  // compare half a cycle after each edge
  always @(negedge clk) begin
    if (m_en && !done_flag) begin
      chk(m_ign ? "R3 busy" : "R2 busy", {15'b0, busy}, {15'b0, m_busy});
      if (m_stat) begin
        chk("R5 dq7", {15'b0, rd_data[7]}, {15'b0, e_rd[7]});
        chk("R6 dq6", {15'b0, rd_data[6]}, {15'b0, e_rd[6]});
        chk("R7 zero bits", {rd_data[15:8], 2'b00, rd_data[5:0]}, 16'h0000);
      end else begin
        chk(e_tag, rd_data, e_rd);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input bit st, input int k, input int a, input logic [15:0] d,
                     input bit re, input int ra);
    op_start = st;
    op_kind  = 2'(k);
    op_addr  = AW'(a);
    op_wdata = d;
    rd_en    = re;
    rd_addr  = AW'(ra);
    @(negedge clk);
    op_start = 1'b0;
    rd_en    = 1'b0;
  endtask

  // start an operation, then poll: reads on the first cycles and every other cycle
  task automatic run_op(input int k, input int a, input logic [15:0] d, input int ncyc);
    cyc(1'b1, k, a, d, 1'b0, 0);
    for (int c = 0; c < ncyc; c++) cyc(1'b0, 0, 0, 16'h0, (c < 3) || (c % 2 == 0), a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {15'b0, busy}, 16'h0000);
    chk("R1 rd_data in reset", rd_data, 16'h0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_en = 1'b1;

    // chip erase, with an ignored program start and back-to-back status reads
    cyc(1'b1, 3, 0, 16'h0, 1'b0, 0);
    for (int i = 0; i < 24; i++)
      cyc(i == 5, 0, 8'h33, 16'h0000, (i % 3 == 0) || (i >= 9 && i <= 12), 8'h33);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h33);
    chk("R3 ignored program left word erased", rd_data, 16'hFFFF);

    // programs with bit 7 clear and set; finish read on the first idle cycle
    run_op(0, 8'h12, 16'h5A3C, TP + 1);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h12);
    cyc(1'b1, 0, 8'h13, 16'h80F1, 1'b1, 8'h12);
    for (int c = 0; c < TP; c++) cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h13);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h13);
    run_op(0, 8'h2A, 16'h1234, TP + 2);
    run_op(0, 8'h47, 16'hBEEF, TP + 2);
    run_op(0, 8'h60, 16'h00C5, TP + 2);
    run_op(0, 8'h16, 16'h7E01, TP + 2);
    for (int a = 8'h10; a < 8'h18; a++) cyc(1'b0, 0, 0, 16'h0, 1'b1, a);

    // sector erase of 10h..17h
    run_op(1, 8'h15, 16'h0, TS + 1);
    foreach (mem[j]) if (j >= 8'h0E && j <= 8'h19) cyc(1'b0, 0, 0, 16'h0, 1'b1, j);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h2A);

    // block erase of 40h..5Fh
    run_op(2, 8'h4C, 16'h0, TB + 1);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h47);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h3F);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h5F);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h60);

    // second chip erase, polled at full rate
    cyc(1'b1, 3, 8'h99, 16'h0, 1'b0, 0);
    for (int c = 0; c < TC; c++) cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h60);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h60);
    cyc(1'b0, 0, 0, 16'h0, 1'b1, 8'h2A);
    repeat (3) @(negedge clk);
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

endmodule